// File: doc/BRIEF.md
# Watchdog Timer with Control and Status Register

The block is a countdown watchdog. A single control register holds two bits. One bit starts and stops the counter. The other is a sticky time-out flag. While the watchdog is enabled it counts down from a programmable period. When the count reaches zero it raises a one-cycle expiry pulse, reloads the period and sets the time-out flag. The flag is also driven out as a status bit for a neighbouring error control register.

The block handles three kinds of reset. A cold reset clears the flag and takes the enable value from a boot-configuration input that disables the watchdog. A warm reset keeps both bits, unless the watchdog itself caused that reset. A warm reset caused by the watchdog reloads the enable bit from the boot configuration. A separate error-enable input decides whether an expiry also switches the watchdog off.

Top module: `wdt_ctl`

## Requirements
- R1: While `rst_n` is low (synchronous cold reset), the enable bit takes the value `~boot_wdt_off`, the time-out flag becomes 0 and the count is loaded from `period`. No expiry pulse is produced during reset.
- R2: `reg_rdata` bit 0 is the enable bit and bit 1 is the time-out flag. All higher bits read as zero, and writing ones to them has no effect.
- R3: While enabled, the count falls by one each cycle. In a cycle where it is zero, `expire` is high for that cycle only and the count reloads from `period`. After a reload, expiries come every `period`+1 cycles.
- R4: Writing the enable bit starts or stops counting without changing the count. While disabled, the count holds and no expiry occurs.
- R5: Expiry sets the time-out flag. The flag stays set until a write with bit 1 equal to 0. A write with bit 1 equal to 1 leaves it unchanged. `tmo_status` always equals the flag.
- R6: If a write clears the flag in the same cycle as an expiry, the flag ends up set.
- R7: On expiry with `err_wdt_en` high, the enable bit clears, and this takes priority over a same-cycle write. With `err_wdt_en` low, the enable bit stays set and counting continues.
- R8: A warm reset (`warm_rst` high, `warm_by_wdt` low) keeps the enable bit and the time-out flag and reloads the count from `period`.
- R9: A warm reset with `warm_by_wdt` high sets the enable bit to `~boot_wdt_off`, keeps the time-out flag and reloads the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous cold reset, active low |
| warm_rst | input | 1 | Synchronous warm reset request, active high |
| warm_by_wdt | input | 1 | Marks the current warm reset as caused by the watchdog |
| boot_wdt_off | input | 1 | Boot-configuration bit that disables the watchdog |
| err_wdt_en | input | 1 | Error-enable bit from the error control register; expiry then clears enable |
| period | input | CNT_W | Reload value of the countdown |
| reg_wr | input | 1 | Write strobe for the control register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Control register read value |
| expire | output | 1 | One-cycle expiry pulse |
| tmo_status | output | 1 | Time-out flag, routed to the error control register |

## Verification
The bench builds the block with `CNT_W` = 6 and the default `DATA_W` of 32. The narrow counter lets it run periods of 2 to 5 cycles and measure exact expiry intervals. It can then place a flag-clearing write or a warm reset in the very cycle of an expiry. The full 32-bit data width keeps the reserved read-as-zero bits within reach of the checks.

// File: rtl/wdt_ctl.sv
module wdt_ctl #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              warm_rst,
  input  logic              warm_by_wdt,
  input  logic              boot_wdt_off,
  input  logic              err_wdt_en,
  input  logic [CNT_W-1:0]  period,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              expire,
  output logic              tmo_status
);
  localparam int EN_BIT = 0;
  localparam int TO_BIT = 1;

  logic             en_q;
  logic             to_q;
  logic [CNT_W-1:0] cnt_q;
  logic             at_zero;

  assign at_zero    = (cnt_q == '0);
  assign expire     = rst_n & ~warm_rst & en_q & at_zero;
  assign tmo_status = to_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= ~boot_wdt_off;
      to_q  <= 1'b0;
      cnt_q <= period;
    end else if (warm_rst) begin
      cnt_q <= period;
      if (warm_by_wdt) en_q <= ~boot_wdt_off;
    end else begin
      if (expire)    cnt_q <= period;
      else if (en_q) cnt_q <= cnt_q - 1'b1;

      if (expire && err_wdt_en) en_q <= 1'b0;
      else if (reg_wr)          en_q <= reg_wdata[EN_BIT];

      if (expire)                             to_q <= 1'b1;
      else if (reg_wr && !reg_wdata[TO_BIT])  to_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata         = '0;
    reg_rdata[EN_BIT] = en_q;
    reg_rdata[TO_BIT] = to_q;
  end

  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> cnt_q == $past(period));
  p_hold_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !warm_rst) |=> $stable(cnt_q));
  p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> tmo_status);
  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_status && !(reg_wr && !reg_wdata[TO_BIT])) |=> tmo_status);
  p_auto_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && err_wdt_en) |=> !reg_rdata[EN_BIT]);
  p_warm_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_rst && !warm_by_wdt) |=> (reg_rdata[EN_BIT] == $past(reg_rdata[EN_BIT])));
  p_warm_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst |=> (tmo_status == $past(tmo_status)));
endmodule

// File: tb/sim_wdt_ctl.sv
module sim_wdt_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 6;

  logic clk = 0, rst_n = 0, warm_rst = 0, warm_by_wdt = 0;
  logic boot_wdt_off = 1, err_wdt_en = 0, reg_wr = 0;
  logic [CNT_W-1:0] period = 6'd3;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic expire, tmo_status;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_ctl #(.CNT_W(CNT_W), .DATA_W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .warm_by_wdt(warm_by_wdt),
    .boot_wdt_off(boot_wdt_off), .err_wdt_en(err_wdt_en), .period(period),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .expire(expire), .tmo_status(tmo_status));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cold(input logic boot_off, input logic [CNT_W-1:0] p);
    boot_wdt_off = boot_off; period = p; rst_n = 0;
    step(2);
    rst_n = 1;
  endtask

  task automatic wr_ctl(input logic [31:0] d);
    reg_wr = 1; reg_wdata = d;
    step(1);
    reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic warm(input logic by_wdt);
    warm_rst = 1; warm_by_wdt = by_wdt;
    step(1);
    warm_rst = 0; warm_by_wdt = 0;
  endtask

  task automatic wait_exp(output int n);
    n = 0;
    while (!expire && n < 200) begin step(1); n++; end
  endtask

  task automatic t_reset;
    int n;
    cold(1'b1, 6'd3);
    chk("R1 rdata boot off", reg_rdata, 32'h0);
    chk("R1 no expire", {31'b0, expire}, 32'h0);
    cold(1'b0, 6'd4);
    chk("R1 rdata boot on", reg_rdata, 32'h1);
    wait_exp(n);
    chk("R1 count loaded", n, 4);
  endtask

  task automatic t_count;
    int n;
    cold(1'b1, 6'd3); err_wdt_en = 0;
    wr_ctl(32'h1);
    wait_exp(n);
    chk("R3 first interval", n, 3);
    step(1);
    chk("R3 pulse one cycle", {31'b0, expire}, 32'h0);
    chk("R7 en kept w/o err_en", reg_rdata, 32'h3);
    wait_exp(n);
    chk("R3 reload interval", n, 3);
  endtask

  task automatic t_pause;
    int n;
    cold(1'b1, 6'd5);
    wr_ctl(32'h1);
    step(2);
    wr_ctl(32'h0);
    for (int i = 0; i < 10; i++) begin
      if (expire) n = 99;
      step(1);
    end
    chk("R4 no expiry while off", reg_rdata, 32'h0);
    wr_ctl(32'h1);
    wait_exp(n);
    chk("R4 count preserved", n, 2);
  endtask

  task automatic t_flag;
    int n;
    cold(1'b1, 6'd2); err_wdt_en = 0;
    wr_ctl(32'h1);
    wait_exp(n);
    step(1);
    chk("R5 flag set", {31'b0, tmo_status}, 32'h1);
    wr_ctl(32'h3);
    chk("R5 write one keeps flag", reg_rdata, 32'h3);
    wait_exp(n);
    wr_ctl(32'h1);
    chk("R6 set beats clear", reg_rdata, 32'h3);
    wr_ctl(32'h1);
    chk("R5 write zero clears", {31'b0, tmo_status}, 32'h0);
    wr_ctl(32'hFFFF_FFFE);
    chk("R2 reserved read zero", reg_rdata, 32'h0);
  endtask

  task automatic t_autooff;
    int n;
    cold(1'b1, 6'd2); err_wdt_en = 1;
    wr_ctl(32'h1);
    wait_exp(n);
    reg_wr = 1; reg_wdata = 32'h3;
    step(1);
    reg_wr = 0; reg_wdata = '0;
    chk("R7 auto disable", reg_rdata, 32'h2);
    n = 0;
    for (int i = 0; i < 8; i++) begin
      if (expire) n++;
      step(1);
    end
    chk("R7 stopped", n, 0);
    err_wdt_en = 0;
  endtask

  task automatic t_warm;
    int n;
    cold(1'b0, 6'd3); err_wdt_en = 0;
    wait_exp(n);
    step(1);
    warm(1'b0);
    chk("R8 keeps en and flag", reg_rdata, 32'h3);
    wait_exp(n);
    chk("R8 count reloaded", n, 3);
    step(1);
    wr_ctl(32'h2);
    warm(1'b0);
    chk("R8 keeps en off", reg_rdata, 32'h2);
    warm(1'b1);
    chk("R9 en from boot on", reg_rdata, 32'h3);
    boot_wdt_off = 1;
    warm(1'b1);
    chk("R9 en from boot off", reg_rdata, 32'h2);
    chk("R9 flag kept", {31'b0, tmo_status}, 32'h1);
  endtask

  initial begin
    step(1);
    t_reset();
    t_count();
    t_pause();
    t_flag();
    t_autooff();
    t_warm();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule